// File: doc/BRIEF.md
# Key Code Queue with CPU Bus and Interrupt

This block sits between a key scanner and a host processor. The scanner offers one key code per cycle on a valid/data pair. The block stores accepted codes in a small first-in first-out queue. The processor reaches it over an 8-bit bus with an active-low chip select, a register-select line, and active-low read and write strobes. A data read returns the oldest code and removes it. A status read returns a summary word: the entry count, a full bit, an underrun bit and an error bit. Command writes can clear the queue and its flags, or briefly drop the interrupt.

The interrupt request tells the processor that codes are waiting. It falls for one cycle after every data read and after an end-interrupt command. In the following cycle it rises again if entries are still stored. A code offered to a full queue is lost and sets a sticky error flag. While that flag is set, no new code is stored. Codes already stored can still be read, and they still raise the interrupt. Every bus access is sampled at a rising clock edge while chip select and the strobe are both low, so a strobe held low for one cycle makes exactly one access.

Top module: `key_queue_top`

## Requirements
- R1: Codes are read back in the order they were accepted, and the queue holds up to DEPTH (8) codes. With the select line at 0, rdata shows the oldest stored code, and a data read removes it at the clock edge.
- R2: A key code offered while the queue is full is discarded and sets the error flag (status bit 6). This holds even when a data read happens in the same cycle.
- R3: While the error flag is set, offered key codes are discarded. Data reads still return the stored codes, and the interrupt still follows the stored entries.
- R4: irq is high in every cycle in which the queue is not empty, except the single cycle after a data read. In that cycle irq is low, and it returns high at the next edge if entries remain.
- R5: A command write (select line 1) with data bits 7:5 = 111 holds irq low for one cycle and leaves the stored codes and the flags unchanged.
- R6: With the select line at 1, rdata is the status word. Bits 2:0 hold the entry count modulo 8, bit 3 is full, bit 5 is underrun, bit 6 is error, and bits 4 and 7 are 0. A status read removes nothing.
- R7: A command write with bits 7:5 = 110 and bit 0 = 1 empties the queue, clears the error and underrun flags, drops irq, and wins over a key code offered in the same cycle. With bit 0 = 0 the command changes nothing.
- R8: A data read from an empty queue returns the last code removed (0 after reset) and sets the sticky underrun flag. The count does not change.
- R9: After a synchronous reset, the count and all flags are 0, irq is 0, and a data read returns 0.
- R10: Bus strobes are ignored while chip select is high. Data writes (select line 0) have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key_valid | input | 1 | Scanner offers a key code this cycle |
| key_code | input | 8 | Key code from the scanner |
| cs_n | input | 1 | Chip select, active low |
| a0 | input | 1 | Register select: 0 selects data, 1 selects command or status |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| wdata | input | 8 | Command byte written by the processor |
| rdata | output | 8 | Oldest code or status word |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-entry queue of 8-bit codes. With that depth, filling to full, overrunning and draining each take only a few cycles. Random traffic therefore keeps reaching the full and empty boundaries, the wrap of the 3-bit count field, and key codes that arrive in the same cycle as reads. Directed steps first walk through overrun, the blocking error flag, underrun, both clear variants and the end-interrupt command.

// File: rtl/key_queue_pkg.sv
package key_queue_pkg;

    // Status word bit positions, decoded by host software
    localparam int ST_FULL_BIT = 3;
    localparam int ST_UND_BIT  = 5;
    localparam int ST_ERR_BIT  = 6;

    // Command opcodes in wdata[7:5]
    localparam logic [2:0] OPC_CLEAR = 3'b110;
    localparam logic [2:0] OPC_EOI   = 3'b111;

    typedef struct packed {
        logic pop;    // data read strobe
        logic clr;    // clear command with flag-clear bit
        logic eoi;    // end-interrupt command
    } bus_req_t;

    typedef struct packed {
        logic err;
        logic und;
        logic irq;
    } flag_t;

    function automatic logic [7:0] pack_status(input logic [2:0] cnt,
                                               input logic full,
                                               input flag_t fl);
        logic [7:0] s;
        s = '0;
        s[2:0] = cnt;
        s[ST_FULL_BIT] = full;
        s[ST_UND_BIT]  = fl.und;
        s[ST_ERR_BIT]  = fl.err;
        return s;
    endfunction

endpackage

// File: rtl/key_queue_bus.sv
module key_queue_bus
    import key_queue_pkg::*;
(
    input  logic       cs_n,
    input  logic       a0,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic [7:0] wdata,
    output bus_req_t   req
);
    logic rd_act;
    logic wr_cmd;

    always_comb begin
        rd_act  = !cs_n && !rd_n;
        wr_cmd  = !cs_n && !wr_n && a0;
        req.pop = rd_act && !a0;
        req.clr = wr_cmd && (wdata[7:5] == OPC_CLEAR) && wdata[0];
        req.eoi = wr_cmd && (wdata[7:5] == OPC_EOI);
    end

endmodule

// File: rtl/key_queue_ring.sv
module key_queue_ring #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              pop,
    input  logic              clr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] head,
    output logic [DATA_W-1:0] last,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic              full,
    output logic              empty,
    output logic              nonempty_next
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  cnt_d;
    logic              push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full    = (count == CNT_MAX);
        empty   = (count == '0);
        push_ok = push && !full && !clr;
        pop_ok  = pop && !empty && !clr;
        if (clr)
            cnt_d = '0;
        else
            cnt_d = count + CNT_W'(push_ok) - CNT_W'(pop_ok);
        nonempty_next = (cnt_d != '0);
        head = mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (push_ok)
            mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            last   <= '0;
        end else begin
            count <= cnt_d;
            if (clr) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
            end else begin
                if (push_ok) wr_ptr <= bump(wr_ptr);
                if (pop_ok) begin
                    rd_ptr <= bump(rd_ptr);
                    last   <= mem[rd_ptr];
                end
            end
        end
    end

    // R1
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        full && !pop && !clr |=> count == CNT_MAX);

    // R1
    pop_drain_chk: assert property (@(posedge clk) disable iff (rst)
        pop && !push && !clr && !empty |=> count == $past(count) - 1'b1);

    // R8
    empty_pop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        pop && empty && !push && !clr |=> empty && $stable(last));

endmodule

// File: rtl/key_queue_flags.sv
module key_queue_flags
    import key_queue_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    input  logic     key_valid,
    input  logic     full,
    input  logic     empty,
    input  logic     nonempty_next,
    output flag_t    fl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            fl <= '0;
        end else if (req.clr) begin
            fl <= '0;
        end else begin
            if (key_valid && full) fl.err <= 1'b1;
            if (req.pop && empty)  fl.und <= 1'b1;
            fl.irq <= (req.pop || req.eoi) ? 1'b0 : nonempty_next;
        end
    end

    // R3
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        fl.err && !req.clr |=> fl.err);

    // R4
    irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
        req.pop |=> !fl.irq);

    // R4
    irq_has_data_chk: assert property (@(posedge clk) disable iff (rst)
        fl.irq |-> !empty);

    // R7
    clear_flags_chk: assert property (@(posedge clk) disable iff (rst)
        req.clr |=> !fl.err && !fl.und && !fl.irq);

endmodule

// File: rtl/key_queue_top.sv
module key_queue_top
    import key_queue_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              key_valid,
    input  logic [DATA_W-1:0] key_code,
    input  logic              cs_n,
    input  logic              a0,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [7:0]        wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    localparam int CNT_W = $clog2(DEPTH+1);

    bus_req_t          req;
    flag_t             fl;
    logic [DATA_W-1:0] head, last;
    logic [CNT_W-1:0]  count;
    logic              full, empty, nonempty_next;
    logic [7:0]        status;
    logic [2:0]        cnt_field;

    key_queue_bus u_bus (
        .cs_n  (cs_n),
        .a0    (a0),
        .rd_n  (rd_n),
        .wr_n  (wr_n),
        .wdata (wdata),
        .req   (req)
    );

    key_queue_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ring (
        .clk           (clk),
        .rst           (rst),
        .push          (key_valid && !fl.err),
        .pop           (req.pop),
        .clr           (req.clr),
        .din           (key_code),
        .head          (head),
        .last          (last),
        .count         (count),
        .full          (full),
        .empty         (empty),
        .nonempty_next (nonempty_next)
    );

    key_queue_flags u_flags (
        .clk           (clk),
        .rst           (rst),
        .req           (req),
        .key_valid     (key_valid),
        .full          (full),
        .empty         (empty),
        .nonempty_next (nonempty_next),
        .fl            (fl)
    );

    always_comb begin
        cnt_field = 3'(count);
        status    = pack_status(cnt_field, full, fl);
        if (a0)
            rdata = DATA_W'(status);
        else
            rdata = empty ? last : head;
        irq = fl.irq;
    end

    // R2
    overrun_err_chk: assert property (@(posedge clk) disable iff (rst)
        key_valid && full && !req.clr |=> fl.err);

    // R3
    err_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        fl.err && !req.pop && !req.clr |=> $stable(count));

    // R5
    eoi_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        req.eoi && !key_valid && !req.pop |=> !irq && $stable(count));

endmodule

// File: tb/key_queue_top_tb_top.sv
module key_queue_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       key_valid = 1'b0;
    logic [7:0] key_code = '0;
    logic       cs_n = 1'b1, a0 = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // reference state
    logic [7:0] q[$];
    bit   m_err, m_und, m_irq;
    logic [7:0] m_last;

    always #2 clk = ~clk;

    key_queue_top dut_i (
        .clk(clk), .rst(rst), .key_valid(key_valid), .key_code(key_code),
        .cs_n(cs_n), .a0(a0), .rd_n(rd_n), .wr_n(wr_n), .wdata(wdata),
        .rdata(rdata), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] m_status();
        logic [7:0] s;
        s = '0;
        s[2:0] = 3'(q.size());
        s[3] = (q.size() == 8);
        s[5] = m_und;
        s[6] = m_err;
        return s;
    endfunction

    task automatic model_edge();
        bit rd, wr, pop, clr, eoi, was_full;
        rd  = !cs_n && !rd_n;
        wr  = !cs_n && !wr_n;
        pop = rd && !a0;
        clr = wr && a0 && (wdata[7:5] == 3'b110) && wdata[0];
        eoi = wr && a0 && (wdata[7:5] == 3'b111);
        if (rst) begin
            q.delete(); m_err = 0; m_und = 0; m_irq = 0; m_last = '0;
        end else if (clr) begin
            q.delete(); m_err = 0; m_und = 0; m_irq = 0;
        end else begin
            was_full = (q.size() == 8);
            if (pop) begin
                if (q.size() == 0) m_und = 1;
                else m_last = q.pop_front();
            end
            if (key_valid) begin
                if (was_full) m_err = 1;
                else if (!m_err) q.push_back(key_code);
            end
            m_irq = (pop || eoi) ? 1'b0 : (q.size() != 0);
        end
    endtask

    task automatic compare();
        logic [7:0] exp;
        if (rst) return;
        if (a0) begin
            exp = m_status();
            chk(rdata === exp, "R6 status word", rdata, exp);
        end else begin
            exp = (q.size() != 0) ? q[0] : m_last;
            chk(rdata === exp, "R1 data output", rdata, exp);
        end
        chk(irq === m_irq, "R4 irq", {7'd0, irq}, {7'd0, m_irq});
    endtask

    // one bus cycle; strobe flags are active high here
    task automatic step(input bit sel, input bit ad, input bit rd, input bit wr,
                        input logic [7:0] d, input bit kv, input logic [7:0] kc);
        @(negedge clk);
        cs_n = !sel; a0 = ad; rd_n = !rd; wr_n = !wr; wdata = d;
        key_valid = kv; key_code = kc;
        @(posedge clk);
        model_edge();
        #1;
        compare();
    endtask

    task automatic idle();        step(0, 1, 0, 0, 8'h00, 0, 8'h00); endtask
    task automatic st_rd();       step(1, 1, 1, 0, 8'h00, 0, 8'h00); endtask
    task automatic dt_rd();       step(1, 0, 1, 0, 8'h00, 0, 8'h00); endtask
    task automatic cmd(input logic [7:0] c); step(1, 1, 0, 1, c, 0, 8'h00); endtask
    task automatic key(input logic [7:0] c); step(0, 1, 0, 0, 8'h00, 1, c); endtask

    initial begin
        #800000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) idle();
        @(negedge clk); rst = 1'b0;
        // R9 reset state
        st_rd();
        chk(rdata == 8'h00, "R9 status after reset", rdata, 8'h00);
        chk(irq == 1'b0, "R9 irq after reset", {7'd0, irq}, 8'h00);
        dt_rd();
        chk(rdata == 8'h00, "R8 empty read returns last", rdata, 8'h00);
        st_rd();
        chk(rdata == 8'h20, "R8 underrun flag", rdata, 8'h20);
        cmd(8'hC1);
        chk(rdata == 8'h00, "R7 clear flags", rdata, 8'h00);
        // R2 fill and overrun
        for (int i = 0; i < 9; i++) key(8'h10 + 8'(i));
        st_rd();
        chk(rdata == 8'h48, "R2 full plus error", rdata, 8'h48);
        chk(irq == 1'b1, "R4 irq with entries", {7'd0, irq}, 8'h01);
        // R5 end interrupt
        cmd(8'hE0);
        chk(irq == 1'b0, "R5 irq dropped", {7'd0, irq}, 8'h00);
        st_rd();
        chk(irq == 1'b1 && rdata == 8'h48, "R5 state kept", rdata, 8'h48);
        // R1 pop, R4 drop
        dt_rd();
        chk(rdata == 8'h11, "R1 next code", rdata, 8'h11);
        chk(irq == 1'b0, "R4 irq low after read", {7'd0, irq}, 8'h00);
        // R3 error blocks new code
        key(8'h55);
        st_rd();
        chk(rdata == 8'h47, "R3 code blocked", rdata, 8'h47);
        chk(irq == 1'b1, "R3 irq continues", {7'd0, irq}, 8'h01);
        for (int i = 0; i < 7; i++) dt_rd();
        dt_rd();
        chk(rdata == 8'h17, "R8 last code repeated", rdata, 8'h17);
        cmd(8'hC0);
        st_rd();
        chk(rdata == 8'h60, "R7 clear without flag bit", rdata, 8'h60);
        cmd(8'hC1);
        // R10 ignored accesses
        key(8'h33);
        step(0, 0, 1, 0, 8'h00, 0, 8'h00);
        step(1, 0, 0, 1, 8'h99, 0, 8'h00);
        st_rd();
        chk(rdata == 8'h01, "R10 ignored strobes", rdata, 8'h01);
        // random traffic
        for (int n = 0; n < 4000; n++) begin
            int r;
            bit kv;
            r  = $urandom_range(0, 19);
            kv = ($urandom_range(0, 9) < 4);
            case (r)
                0,1,2,3,4,5: step(1, 0, 1, 0, 8'h00, kv, 8'($urandom));
                6,7,8:       step(1, 1, 1, 0, 8'h00, kv, 8'($urandom));
                9:           step(1, 1, 0, 1, 8'hE0, kv, 8'($urandom));
                10:          step(1, 1, 0, 1, ($urandom_range(0, 3) == 0) ? 8'hC1 : 8'hC0,
                                  kv, 8'($urandom));
                11:          step(0, 0, 1, 1, 8'hC1, kv, 8'($urandom));
                default:     step(0, 1, 0, 0, 8'h00, 1, 8'($urandom));
            endcase
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule